// File: doc/BRIEF.md
# Instruction Prefix Sequence Decoder

This block sits between instruction fetch and the main opcode decoder of an extended 8-bit CPU. It takes fetched instruction bytes one at a time and looks for prefix bytes that widen the next instruction. A pair of 0x42 bytes asks for 32-bit data ("quad" mode). A lone 0xEA byte asks for 32-bit pointer ("long") mode. Both chained, 0x42 0x42 0xEA, ask for the two together. Prefix bytes produce no instruction of their own.

When the final opcode byte arrives, the block emits one strobe. With it come the opcode, a mode tag, an addressing-mode class and an illegal flag. The addressing class reflects how the prefix reinterprets the opcode. In quad mode, the z-indexed indirect column becomes plain indirect, and the accumulator shifts act on the wide register. Cells with no quad meaning, including every immediate form, are flagged illegal. Long and combined modes accept only the eight x2-with-odd-high-nibble opcodes. A single 0x42 that is not followed by a second one is released as an ordinary opcode. The following byte is then decoded from scratch.

Top module: `pfx_decoder_top`

## Requirements
- R1: While reset is held, and after it is released, out_strobe is low and in_ready is high. A reset in the middle of a prefix sequence discards the prefix, so the next opcode is tagged normal (mode 0).
- R2: A byte accepted with no prefix pending, other than 0x42 or 0xEA, produces out_strobe for exactly one cycle, starting the cycle after acceptance. It carries out_opcode equal to the byte, out_mode 0 and out_illegal 0. out_amode is 10 (z-indexed indirect) when the byte's low five bits are 0x12, and 15 (base table) otherwise.
- R3: The sequence 0x42 0x42 X, with X not 0xEA, yields one strobe with out_mode 1 (quad) and out_opcode X.
- R4: The sequence 0xEA X yields out_mode 2 (long). If X[4:0]==0x12, the class is 11 (z-indexed through a 4-byte pointer) and the instruction is legal. Any other X gives class 0 and out_illegal 1.
- R5: The sequence 0x42 0x42 0xEA X yields out_mode 3 (quad+long). If X[4:0]==0x12, the class is 12 (4-byte pointer, no index) and the instruction is legal. Any other X gives class 0 and out_illegal 1.
- R6: In quad mode, opcodes with X[1:0]==01 are classified by X[4:2]:
  - 0 gives class 7, indexed indirect.
  - 1 gives class 2, zero page.
  - 2 is the immediate form, so it is illegal: class 0, out_illegal 1.
  - 3 gives class 4, absolute.
  - 4 gives class 8, indirect indexed by y.
  - 5 gives class 3, zero page indexed by x.
  - 6 gives class 6, absolute indexed by y.
  - 7 gives class 5, absolute indexed by x.
- R7: In quad mode, an opcode with X[4:0]==0x12 is classified as plain indirect (class 9), not z-indexed.
- R8: In quad mode, 0x0A, 0x2A, 0x4A, 0x6A, 0x1A and 0x3A are implied (class 1). The shift/rotate opcodes (X[7:5] 0..3) and the increment/decrement opcodes (X[7:5] 6..7), with X[1:0]==10, get memory classes: X[4:2]=1 gives 2, 3 gives 4, 5 gives 3, and 7 gives 5. 0x5A, 0x7A and 0xCA are illegal.
- R9: In quad mode, 0x82 and 0xE2 are class 13 (stack-relative indirect indexed by y). Every opcode with X[1:0] of 00 or 11 is illegal, as is every X[1:0]==10 cell with X[7:5] of 4 or 5 that is outside R7 and 0x82. This includes a third 0x42.
- R10: When 0x42 is followed by a byte other than 0x42, in_ready is low for that byte for one cycle. During that cycle 0x42 is emitted as a normal opcode (mode 0, class 15). The held byte is then accepted and decoded with no prefix pending.
- R11: A prefix applies to one opcode only. The opcode after a prefixed instruction is tagged normal unless it carries its own prefix.
- R12: One byte is accepted per cycle while in_valid is high and in_ready is high. Prefix bytes produce no strobe, and back-to-back ordinary bytes produce strobes in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Fetched byte present |
| in_byte | input | 8 | Fetched instruction byte |
| in_ready | output | 1 | Byte is taken this cycle when in_valid is high |
| out_strobe | output | 1 | One-cycle pulse per decoded instruction |
| out_opcode | output | 8 | Final opcode byte |
| out_mode | output | 2 | 0 normal, 1 quad, 2 long, 3 quad+long |
| out_amode | output | 4 | Addressing-mode class code |
| out_illegal | output | 1 | Opcode has no meaning in the selected mode |

## Verification
The assertions assume the usual handshake rule: while in_valid is high and in_ready is low, the source keeps in_valid high and in_byte unchanged. Under that rule, the stall check can rely on a lone 0x42 being released on the very next cycle. The stimulus tasks raise in_valid with a byte and hold both until they see in_ready high before a clock edge. This covers both single bytes and back-to-back streams, including the stall that follows a lone 0x42.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_NORM  = 2'd0,
    MODE_QUAD  = 2'd1,
    MODE_LONG  = 2'd2,
    MODE_QLONG = 2'd3
  } xmode_e;

  typedef enum logic [3:0] {
    AM_NONE   = 4'd0,
    AM_IMPL   = 4'd1,
    AM_ZP     = 4'd2,
    AM_ZPX    = 4'd3,
    AM_ABS    = 4'd4,
    AM_ABSX   = 4'd5,
    AM_ABSY   = 4'd6,
    AM_INDX   = 4'd7,
    AM_INDY   = 4'd8,
    AM_IND    = 4'd9,
    AM_INDZ   = 4'd10,
    AM_LINDZ  = 4'd11,
    AM_LIND   = 4'd12,
    AM_SPINDY = 4'd13,
    AM_RSVD   = 4'd14,
    AM_BASE   = 4'd15
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAW1  = 3'd1,
    ST_QUAD  = 3'd2,
    ST_LONG  = 3'd3,
    ST_QLONG = 3'd4
  } pst_e;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    xmode_e            mode;
    amode_e            am;
    logic              ill;
  } dec_t;

endpackage

// File: rtl/pfx_seq_fsm.sv
module pfx_seq_fsm
  import pfx_dec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] QUAD_PFX = 8'h42,
  parameter logic [BYTE_W-1:0] LONG_PFX = 8'hEA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output pst_e              st_q,
  output logic              fire,
  output logic [BYTE_W-1:0] fire_op,
  output xmode_e            fire_mode
);

  pst_e st_d;
  logic acc;
  logic is_quad_b;
  logic is_long_b;
  logic st_en;

  assign is_quad_b = (in_byte == QUAD_PFX);
  assign is_long_b = (in_byte == LONG_PFX);

  // A lone first prefix byte is flushed before the next byte is taken.
  assign in_ready = !((st_q == ST_SAW1) && in_valid && !is_quad_b);
  assign acc      = in_valid && in_ready;

  always_comb begin
    st_d      = st_q;
    fire      = 1'b0;
    fire_op   = in_byte;
    fire_mode = MODE_NORM;
    unique case (st_q)
      ST_IDLE: begin
        if (acc) begin
          if (is_quad_b)      st_d = ST_SAW1;
          else if (is_long_b) st_d = ST_LONG;
          else                fire = 1'b1;
        end
      end
      ST_SAW1: begin
        if (in_valid) begin
          if (is_quad_b) begin
            st_d = ST_QUAD;
          end else begin
            fire    = 1'b1;
            fire_op = QUAD_PFX;
            st_d    = ST_IDLE;
          end
        end
      end
      ST_QUAD: begin
        if (acc) begin
          if (is_long_b) begin
            st_d = ST_QLONG;
          end else begin
            fire      = 1'b1;
            fire_mode = MODE_QUAD;
            st_d      = ST_IDLE;
          end
        end
      end
      ST_LONG: begin
        if (acc) begin
          fire      = 1'b1;
          fire_mode = MODE_LONG;
          st_d      = ST_IDLE;
        end
      end
      ST_QLONG: begin
        if (acc) begin
          fire      = 1'b1;
          fire_mode = MODE_QLONG;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/pfx_quad_class.sv
module pfx_quad_class
  import pfx_dec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SPREL_ST = 8'h82,
  parameter logic [BYTE_W-1:0] SPREL_LD = 8'hE2,
  parameter logic [BYTE_W-1:0] INC_IMP  = 8'h1A,
  parameter logic [BYTE_W-1:0] DEC_IMP  = 8'h3A
) (
  input  logic [BYTE_W-1:0] op,
  output amode_e            am
);

  logic [2:0] grp;
  logic [2:0] row;
  logic [1:0] col;
  logic       rmw_grp;
  logic       shift_grp;

  assign grp       = op[7:5];
  assign row       = op[4:2];
  assign col       = op[1:0];
  assign shift_grp = (grp <= 3'd3);
  assign rmw_grp   = shift_grp || (grp >= 3'd6);

  always_comb begin
    am = AM_NONE;
    unique case (col)
      2'b01: begin
        unique case (row)
          3'd0: am = AM_INDX;
          3'd1: am = AM_ZP;
          3'd2: am = AM_NONE;
          3'd3: am = AM_ABS;
          3'd4: am = AM_INDY;
          3'd5: am = AM_ZPX;
          3'd6: am = AM_ABSY;
          default: am = AM_ABSX;
        endcase
      end
      2'b10: begin
        if (row == 3'd4) begin
          am = AM_IND;
        end else if (row == 3'd0) begin
          am = ((op == SPREL_ST) || (op == SPREL_LD)) ? AM_SPINDY : AM_NONE;
        end else if (row == 3'd6) begin
          am = ((op == INC_IMP) || (op == DEC_IMP)) ? AM_IMPL : AM_NONE;
        end else if (!rmw_grp) begin
          am = AM_NONE;
        end else begin
          unique case (row)
            3'd1: am = AM_ZP;
            3'd2: am = shift_grp ? AM_IMPL : AM_NONE;
            3'd3: am = AM_ABS;
            3'd5: am = AM_ZPX;
            3'd7: am = AM_ABSX;
            default: am = AM_NONE;
          endcase
        end
      end
      default: am = AM_NONE;
    endcase
  end

endmodule

// File: rtl/pfx_ext_class.sv
module pfx_ext_class
  import pfx_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  xmode_e            mode,
  output dec_t              dec
);

  localparam logic [4:0] PTR_COL = 5'h12;

  amode_e quad_am;
  amode_e am;
  logic   ptr_col;

  assign ptr_col = (op[4:0] == PTR_COL);

  pfx_quad_class quad_cls_i (
    .op (op),
    .am (quad_am)
  );

  always_comb begin
    unique case (mode)
      MODE_QUAD:  am = quad_am;
      MODE_LONG:  am = ptr_col ? AM_LINDZ : AM_NONE;
      MODE_QLONG: am = ptr_col ? AM_LIND  : AM_NONE;
      default:    am = ptr_col ? AM_INDZ  : AM_BASE;
    endcase
  end

  always_comb begin
    dec.op   = op;
    dec.mode = mode;
    dec.am   = am;
    dec.ill  = (am == AM_NONE);
  end

endmodule

// File: rtl/pfx_decoder_top.sv
module pfx_decoder_top
  import pfx_dec_pkg::*;
#(
  parameter logic [7:0] QUAD_PFX = 8'h42,
  parameter logic [7:0] LONG_PFX = 8'hEA,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       out_strobe,
  output logic [7:0] out_opcode,
  output logic [1:0] out_mode,
  output logic [3:0] out_amode,
  output logic       out_illegal
);

  localparam int SYNC_W = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;

  pst_e              st_q;
  logic              fire;
  logic [BYTE_W-1:0] fire_op;
  xmode_e            fire_mode;
  dec_t              dec;
  dec_t              dec_q;
  logic              strobe_q;

  // Reset asserts at once and leaves after SYNC_W clock edges.
  generate
    if (SYNC_W == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= 1'b0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_W-1];

  pfx_seq_fsm #(
    .QUAD_PFX (QUAD_PFX),
    .LONG_PFX (LONG_PFX)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .st_q      (st_q),
    .fire      (fire),
    .fire_op   (fire_op),
    .fire_mode (fire_mode)
  );

  pfx_ext_class cls_i (
    .op   (fire_op),
    .mode (fire_mode),
    .dec  (dec)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dec_q <= '0;
    end else if (fire) begin
      dec_q <= dec;
    end
  end

  assign out_strobe  = strobe_q;
  assign out_opcode  = dec_q.op;
  assign out_mode    = dec_q.mode;
  assign out_amode   = dec_q.am;
  assign out_illegal = dec_q.ill;

endmodule

// File: rtl/pfx_decoder_chk.sv
module pfx_decoder_chk
  import pfx_dec_pkg::*;
#(
  parameter logic [7:0] QUAD_PFX = 8'h42,
  parameter logic [7:0] LONG_PFX = 8'hEA
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       in_ready,
  input logic       out_strobe,
  input logic [7:0] out_opcode,
  input logic [1:0] out_mode,
  input logic [3:0] out_amode,
  input logic       out_illegal,
  input pst_e       st_q
);

  AST_NORMAL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && out_mode == 2'd0) |-> !out_illegal); // R2

  AST_QUAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && st_q == ST_QUAD && in_byte != LONG_PFX)
      |=> (out_strobe && out_mode == 2'd1 && out_opcode == $past(in_byte))); // R3

  AST_LONG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && out_mode == 2'd2 && !out_illegal)
      |-> (out_opcode[4:0] == 5'h12 && out_amode == 4'd11)); // R4

  AST_QLONG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && out_mode == 2'd3 && !out_illegal)
      |-> (out_opcode[4:0] == 5'h12 && out_amode == 4'd12)); // R5

  AST_QUAD_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && out_mode == 2'd1 && out_opcode[4:0] == 5'h09)
      |-> out_illegal); // R6

  AST_QUAD_PLAIN_IND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && out_mode == 2'd1 && out_opcode[4:0] == 5'h12)
      |-> (out_amode == 4'd9 && !out_illegal)); // R7

  AST_LONE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready)
      |=> (out_strobe && out_opcode == QUAD_PFX && out_mode == 2'd0)); // R10

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_byte))); // R10

  AST_ONE_SHOT_PFX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && out_mode != 2'd0) |=> (!out_strobe || out_mode == 2'd0)); // R11

  AST_PFX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && st_q == ST_IDLE && in_byte == LONG_PFX)
      |=> !out_strobe); // R12

endmodule

bind pfx_decoder_top pfx_decoder_chk #(
  .QUAD_PFX (QUAD_PFX),
  .LONG_PFX (LONG_PFX)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_byte     (in_byte),
  .in_ready    (in_ready),
  .out_strobe  (out_strobe),
  .out_opcode  (out_opcode),
  .out_mode    (out_mode),
  .out_amode   (out_amode),
  .out_illegal (out_illegal),
  .st_q        (st_q)
);

// File: tb/pfx_decoder_top_tb_top.sv
`timescale 1ns/1ps
module pfx_decoder_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ready;
  logic       out_strobe;
  logic [7:0] out_opcode;
  logic [1:0] out_mode;
  logic [3:0] out_amode;
  logic       out_illegal;

  int checks = 0;
  int errors = 0;
  int rec_n  = 0;
  int cyc    = 0;
  int stalls = 0;
  logic [7:0] rec_op   [256];
  logic [1:0] rec_mode [256];
  logic [3:0] rec_am   [256];
  logic       rec_ill  [256];
  int         rec_cyc  [256];

  pfx_decoder_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_ready    (in_ready),
    .out_strobe  (out_strobe),
    .out_opcode  (out_opcode),
    .out_mode    (out_mode),
    .out_amode   (out_amode),
    .out_illegal (out_illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_strobe && rec_n < 256) begin
      rec_op[rec_n]   = out_opcode;
      rec_mode[rec_n] = out_mode;
      rec_am[rec_n]   = out_amode;
      rec_ill[rec_n]  = out_illegal;
      rec_cyc[rec_n]  = cyc;
      rec_n           = rec_n + 1;
    end
  end

  // {count, b0, b1, b2, b3, opcode, mode, class, illegal}
  localparam int NV = 24;
  localparam logic [49:0] VEC [NV] = '{
    {3'd1, 8'hA9, 8'h00, 8'h00, 8'h00, 8'hA9, 2'd0, 4'd15, 1'b0}, // R2
    {3'd1, 8'h12, 8'h00, 8'h00, 8'h00, 8'h12, 2'd0, 4'd10, 1'b0}, // R2
    {3'd3, 8'h42, 8'h42, 8'hA5, 8'h00, 8'hA5, 2'd1, 4'd2,  1'b0}, // R3 R6
    {3'd3, 8'h42, 8'h42, 8'h09, 8'h00, 8'h09, 2'd1, 4'd0,  1'b1}, // R6
    {3'd3, 8'h42, 8'h42, 8'hBD, 8'h00, 8'hBD, 2'd1, 4'd5,  1'b0}, // R6
    {3'd3, 8'h42, 8'h42, 8'h81, 8'h00, 8'h81, 2'd1, 4'd7,  1'b0}, // R6
    {3'd3, 8'h42, 8'h42, 8'hB1, 8'h00, 8'hB1, 2'd1, 4'd8,  1'b0}, // R6
    {3'd3, 8'h42, 8'h42, 8'h79, 8'h00, 8'h79, 2'd1, 4'd6,  1'b0}, // R6
    {3'd3, 8'h42, 8'h42, 8'hB2, 8'h00, 8'hB2, 2'd1, 4'd9,  1'b0}, // R7
    {3'd3, 8'h42, 8'h42, 8'h0A, 8'h00, 8'h0A, 2'd1, 4'd1,  1'b0}, // R8
    {3'd3, 8'h42, 8'h42, 8'h1A, 8'h00, 8'h1A, 2'd1, 4'd1,  1'b0}, // R8
    {3'd3, 8'h42, 8'h42, 8'h3A, 8'h00, 8'h3A, 2'd1, 4'd1,  1'b0}, // R8
    {3'd3, 8'h42, 8'h42, 8'h5A, 8'h00, 8'h5A, 2'd1, 4'd0,  1'b1}, // R8
    {3'd3, 8'h42, 8'h42, 8'hDE, 8'h00, 8'hDE, 2'd1, 4'd5,  1'b0}, // R8
    {3'd3, 8'h42, 8'h42, 8'hCA, 8'h00, 8'hCA, 2'd1, 4'd0,  1'b1}, // R8
    {3'd3, 8'h42, 8'h42, 8'h96, 8'h00, 8'h96, 2'd1, 4'd0,  1'b1}, // R9
    {3'd3, 8'h42, 8'h42, 8'hE2, 8'h00, 8'hE2, 2'd1, 4'd13, 1'b0}, // R9
    {3'd3, 8'h42, 8'h42, 8'hFF, 8'h00, 8'hFF, 2'd1, 4'd0,  1'b1}, // R9
    {3'd3, 8'h42, 8'h42, 8'h42, 8'h00, 8'h42, 2'd1, 4'd0,  1'b1}, // R9
    {3'd2, 8'hEA, 8'h92, 8'h00, 8'h00, 8'h92, 2'd2, 4'd11, 1'b0}, // R4
    {3'd2, 8'hEA, 8'hB1, 8'h00, 8'h00, 8'hB1, 2'd2, 4'd0,  1'b1}, // R4
    {3'd4, 8'h42, 8'h42, 8'hEA, 8'hD2, 8'hD2, 2'd3, 4'd12, 1'b0}, // R5
    {3'd4, 8'h42, 8'h42, 8'hEA, 8'h12, 8'h12, 2'd3, 4'd12, 1'b0}, // R5
    {3'd4, 8'h42, 8'h42, 8'hEA, 8'hA5, 8'hA5, 2'd3, 4'd0,  1'b1}  // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    bit r;
    in_valid = 1'b1;
    in_byte  = b;
    forever begin
      #1;
      r = in_ready;
      if (!r) stalls++;
      @(negedge clk);
      if (r) break;
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_byte  = 8'h00;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check(out_strobe == 1'b0, "R1 strobe in reset", out_strobe, 0);
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_rec(input int idx, input string req, input logic [7:0] op,
                           input logic [1:0] md, input logic [3:0] am, input logic il);
    check(rec_op[idx] == op, req, rec_op[idx], op);
    check(rec_mode[idx] == md, req, rec_mode[idx], md);
    check(rec_am[idx] == am, req, rec_am[idx], am);
    check(rec_ill[idx] == il, req, rec_ill[idx], il);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    int st0;
    logic [49:0] v;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    rst_n    = 1'b0;
    @(negedge clk);
    do_reset();
    check(out_strobe == 1'b0, "R1 strobe after reset", out_strobe, 0);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      v    = VEC[i];
      base = rec_n;
      for (int k = 0; k < int'(v[49:47]); k++) push(v[46-8*k -: 8]);
      idle(3);
      check(rec_n - base == 1, $sformatf("vector %0d strobe count", i), rec_n - base, 1);
      check_rec(base, $sformatf("vector %0d", i), v[14:7], v[6:5], v[4:1], v[0]);
    end

    // R10: lone 0x42 then ordinary byte
    base = rec_n;
    st0  = stalls;
    push(8'h42);
    push(8'hA9);
    idle(3);
    check(rec_n - base == 2, "R10 lone prefix count", rec_n - base, 2);
    check_rec(base, "R10 lone prefix flushed", 8'h42, 2'd0, 4'd15, 1'b0);
    check_rec(base + 1, "R10 held byte", 8'hA9, 2'd0, 4'd15, 1'b0);
    check(stalls - st0 == 1, "R10 stall cycles", stalls - st0, 1);

    // R10: lone 0x42 then long prefix
    base = rec_n;
    push(8'h42);
    push(8'hEA);
    push(8'h92);
    idle(3);
    check(rec_n - base == 2, "R10 lone then long count", rec_n - base, 2);
    check_rec(base, "R10 lone before long", 8'h42, 2'd0, 4'd15, 1'b0);
    check_rec(base + 1, "R10 long after lone", 8'h92, 2'd2, 4'd11, 1'b0);

    // R11: prefix covers one opcode
    base = rec_n;
    push(8'h42);
    push(8'h42);
    push(8'hA5);
    push(8'hA5);
    idle(3);
    check(rec_n - base == 2, "R11 count", rec_n - base, 2);
    check_rec(base, "R11 prefixed", 8'hA5, 2'd1, 4'd2, 1'b0);
    check_rec(base + 1, "R11 following normal", 8'hA5, 2'd0, 4'd15, 1'b0);

    // R12: back-to-back stream with prefixes
    base = rec_n;
    st0  = stalls;
    push(8'hA9);
    push(8'hAD);
    push(8'hB1);
    push(8'hEA);
    push(8'h32);
    idle(3);
    check(rec_n - base == 4, "R12 count", rec_n - base, 4);
    check(rec_cyc[base + 2] - rec_cyc[base] == 2, "R12 consecutive strobes",
          rec_cyc[base + 2] - rec_cyc[base], 2);
    check(rec_cyc[base + 3] - rec_cyc[base + 2] == 2, "R12 prefix byte silent",
          rec_cyc[base + 3] - rec_cyc[base + 2], 2);
    check(stalls == st0, "R12 no stall", stalls - st0, 0);
    check_rec(base + 3, "R12 long in stream", 8'h32, 2'd2, 4'd11, 1'b0);

    // R1: reset in the middle of a prefix
    base = rec_n;
    push(8'h42);
    push(8'h42);
    idle(1);
    do_reset();
    push(8'hA9);
    idle(3);
    check(rec_n - base == 1, "R1 mid-prefix reset count", rec_n - base, 1);
    check_rec(base, "R1 prefix discarded", 8'hA9, 2'd0, 4'd15, 1'b0);

    finish_run();
  end

endmodule